// File: doc/BRIEF.md
# Descriptor Table Entry Fetcher

This block turns a segment selector or an interrupt vector into the memory address of one 8-byte descriptor and reads that descriptor. Three tables are known to it: a global table, the currently loaded local table, and an interrupt table. Each table is described by a base/limit register pair. The base is a 32-bit physical address. The limit is the table size in bytes minus one. A plain write port loads these register pairs. For the local table, this port loads the hidden base/limit copy that describes the current local table.

A request is accepted only while the block is idle. The block decides which table to use and forms the entry address as base plus eight times the index. It then checks that the entire 8-byte entry lies inside the table. An entry that passes is read as two 32-bit words over a request/acknowledge memory port, and the two words are returned as one 64-bit descriptor. An entry that fails produces a fault pulse with a reason code and no memory traffic. The block does not interpret what the descriptor contains.

Top module: `dtab_fetch`

## Requirements
- R1: After reset, `busy`, `mem_req`, `done` and `fault` are all 0.
- R2: For a selector request (`req_kind`=0), the index is `req_sel[15:3]`. Bit 2 of the selector picks the table: 0 selects the global table and 1 selects the local table. Bits 1:0 have no effect. The first read goes to base + index×8, with 32-bit wrap-around.
- R3: For a vector request (`req_kind`=1), the 8-bit `req_vec` is the index into the interrupt table. The first read goes to interrupt base + vector×8.
- R4: An entry is in range only when index×8+7 ≤ limit. An entry out of range raises `fault` with `fault_code`=1 one cycle after acceptance, and `mem_req` is never asserted for it.
- R5: A selector request that targets the global table with index 0 faults with `fault_code`=2 (null selector), and this check takes priority over the limit check. Index 0 of the local table is fetched normally.
- R6: A fetch that is in range makes exactly two reads. The first read is at the entry address and the second is at entry address + 4. Each read holds `mem_req` and a stable `mem_addr` until `mem_ack` arrives, whatever the number of wait cycles.
- R7: One cycle after the second acknowledge, `done` pulses for one cycle. At that point `desc` holds {second word, first word}, with the first word in bits 31:0.
- R8: `req_valid` is ignored while `busy` is 1. Such a request causes no extra read and no extra done or fault pulse.
- R9: `busy` is 1 from the cycle after acceptance through the cycle of the done or fault pulse, and 0 in the cycle after that. `done` and `fault` are never 1 at the same time.
- R10: A write with `cfg_we`=1 loads `cfg_base` and `cfg_limit` into the table chosen by `cfg_sel`: 0 for global, 1 for local, 2 for interrupt. A write with `cfg_sel`=3 changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table register write strobe |
| cfg_sel | input | 2 | Table to write (0 global, 1 local, 2 interrupt) |
| cfg_base | input | 32 | Table base address to write |
| cfg_limit | input | 16 | Table limit (size - 1) to write |
| req_valid | input | 1 | Fetch request, taken when idle |
| req_kind | input | 1 | 0 selector request, 1 vector request |
| req_sel | input | 16 | Selector |
| req_vec | input | 8 | Interrupt vector |
| busy | output | 1 | Fetch in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| done | output | 1 | Descriptor ready pulse |
| fault | output | 1 | Fault pulse |
| fault_code | output | 2 | 1 limit fault, 2 null selector |
| desc | output | 64 | Assembled descriptor |

## Verification
The bench sweeps indices across each table's limit, including limits that do not end on an 8-byte boundary. A checker that compared only the first byte of the entry, or that used a strict less-than, would fetch an entry that overhangs the table or would reject the last entry that fits. The bench varies the selector's low bits and bit 2 together with index 0. A design that folded the privilege bits into the index, or that treated local index 0 as null, would produce a wrong address or a spurious fault. Memory wait states of zero to three cycles, together with repeated requests while busy, expose a design that drops a word, swaps the halves, moves the address during a stall, or starts a second fetch.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
   typedef enum logic [1:0] {
      TBL_GLOBAL = 2'd0,
      TBL_LOCAL  = 2'd1,
      TBL_INTR   = 2'd2,
      TBL_NONE   = 2'd3
   } tbl_e;

   typedef enum logic [1:0] {
      FLT_NONE  = 2'd0,
      FLT_LIMIT = 2'd1,
      FLT_NULL  = 2'd2
   } flt_e;

   localparam int unsigned NUM_TABLES  = 3;
   localparam int unsigned ENTRY_SHIFT = 3;
endpackage

// File: rtl/dtf_tblregs.sv
module dtf_tblregs #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LIM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [LIM_W-1:0]  wr_limit,
   input  logic [1:0]        rd_sel,
   output logic [ADDR_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_limit
);
   import dtf_pkg::*;

   logic [ADDR_W-1:0] base_q  [NUM_TABLES];
   logic [LIM_W-1:0]  limit_q [NUM_TABLES];

   for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[t]  <= '0;
            limit_q[t] <= '0;
         end else if (wr_en && (wr_sel == 2'(t))) begin
            base_q[t]  <= wr_base;
            limit_q[t] <= wr_limit;
         end
      end
   end

   always_comb begin
      rd_base  = '0;
      rd_limit = '0;
      for (int t = 0; t < NUM_TABLES; t++) begin
         if (rd_sel == 2'(t)) begin
            rd_base  = base_q[t];
            rd_limit = limit_q[t];
         end
      end
   end

   // R10
   ignore_sel3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3) |=>
         ($stable(base_q[0]) && $stable(base_q[1]) && $stable(base_q[2]) &&
          $stable(limit_q[0]) && $stable(limit_q[1]) && $stable(limit_q[2])));
endmodule

// File: rtl/dtf_entry_calc.sv
module dtf_entry_calc #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LIM_W  = 16,
   parameter int unsigned SEL_W  = 16,
   parameter int unsigned VEC_W  = 8
) (
   input  logic              kind,
   input  logic [SEL_W-1:0]  sel,
   input  logic [VEC_W-1:0]  vec,
   output logic [1:0]        tbl,
   input  logic [ADDR_W-1:0] base,
   input  logic [LIM_W-1:0]  limit,
   output logic [ADDR_W-1:0] entry_addr,
   output logic [1:0]        flt
);
   import dtf_pkg::*;

   localparam int unsigned IDX_W = SEL_W - ENTRY_SHIFT;
   localparam int unsigned MAXI  = (IDX_W > VEC_W) ? IDX_W : VEC_W;
   localparam int unsigned OFF_W = MAXI + ENTRY_SHIFT;
   localparam int unsigned CMP_W = (OFF_W > LIM_W) ? OFF_W : LIM_W;

   logic [IDX_W-1:0] idx;
   logic [OFF_W-1:0] off;
   logic [CMP_W-1:0] last_byte;
   logic             is_null;
   logic             over;
   logic             unused_low;

   assign idx        = sel[SEL_W-1:ENTRY_SHIFT];
   assign unused_low = ^sel[1:0];

   always_comb begin
      if (kind)        tbl = TBL_INTR;
      else if (sel[2]) tbl = TBL_LOCAL;
      else             tbl = TBL_GLOBAL;
   end

   always_comb begin
      if (kind) off = OFF_W'({vec, {ENTRY_SHIFT{1'b0}}});
      else      off = OFF_W'({idx, {ENTRY_SHIFT{1'b0}}});
   end

   generate
      if (OFF_W >= ADDR_W) begin : g_addr_trunc
         assign entry_addr = base + off[ADDR_W-1:0];
      end else begin : g_addr_ext
         assign entry_addr = base + ADDR_W'(off);
      end
   endgenerate

   assign last_byte = CMP_W'(off) | CMP_W'((1 << ENTRY_SHIFT) - 1);
   assign over      = last_byte > CMP_W'(limit);
   assign is_null   = !kind && !sel[2] && (idx == '0);

   always_comb begin
      if (is_null)   flt = FLT_NULL;
      else if (over) flt = FLT_LIMIT;
      else           flt = FLT_NONE;
   end
endmodule

// File: rtl/dtf_fetch_seq.sv
module dtf_fetch_seq #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [1:0]        start_flt,
   output logic              busy,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              done,
   output logic              fault,
   output logic [1:0]        fault_code,
   output logic [2*WORD_W-1:0] desc
);
   import dtf_pkg::*;

   localparam int unsigned STEP = WORD_W / 8;

   typedef enum logic [2:0] {S_IDLE, S_LO, S_HI, S_DONE, S_FLT} st_e;

   st_e               st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [1:0]        flt_q;
   logic [WORD_W-1:0] lo_q;
   logic [2*WORD_W-1:0] desc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         addr_q <= '0;
         flt_q  <= FLT_NONE;
         lo_q   <= '0;
         desc_q <= '0;
      end else begin
         case (st_q)
            S_IDLE: if (start) begin
               addr_q <= start_addr;
               flt_q  <= start_flt;
               st_q   <= (start_flt == FLT_NONE) ? S_LO : S_FLT;
            end
            S_LO: if (mem_ack) begin
               lo_q <= mem_rdata;
               st_q <= S_HI;
            end
            S_HI: if (mem_ack) begin
               desc_q <= {mem_rdata, lo_q};
               st_q   <= S_DONE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != S_IDLE);
   assign mem_req    = (st_q == S_LO) || (st_q == S_HI);
   assign mem_addr   = (st_q == S_HI) ? addr_q + ADDR_W'(STEP) : addr_q;
   assign done       = (st_q == S_DONE);
   assign fault      = (st_q == S_FLT);
   assign fault_code = flt_q;
   assign desc       = desc_q;

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R7
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_ack));

   // R4
   fault_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (!mem_req && $past(!busy)));
endmodule

// File: rtl/dtab_fetch.sv
module dtab_fetch #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LIM_W  = 16,
   parameter int unsigned SEL_W  = 16,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned WORD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_sel,
   input  logic [ADDR_W-1:0]   cfg_base,
   input  logic [LIM_W-1:0]    cfg_limit,
   input  logic                req_valid,
   input  logic                req_kind,
   input  logic [SEL_W-1:0]    req_sel,
   input  logic [VEC_W-1:0]    req_vec,
   output logic                busy,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic                mem_ack,
   input  logic [WORD_W-1:0]   mem_rdata,
   output logic                done,
   output logic                fault,
   output logic [1:0]          fault_code,
   output logic [2*WORD_W-1:0] desc
);
   initial begin
      params_chk: assert (SEL_W >= 4 && WORD_W % 8 == 0 && 2 * WORD_W / 8 == 8
                          && LIM_W <= ADDR_W && VEC_W >= 1)
         else $error("dtab_fetch: unsupported parameter set");
   end

   logic [1:0]        tbl;
   logic [ADDR_W-1:0] tbl_base;
   logic [LIM_W-1:0]  tbl_limit;
   logic [ADDR_W-1:0] entry_addr;
   logic [1:0]        flt;
   logic              accept;

   assign accept = req_valid && !busy;

   dtf_tblregs #(.ADDR_W(ADDR_W), .LIM_W(LIM_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_sel   (cfg_sel),
      .wr_base  (cfg_base),
      .wr_limit (cfg_limit),
      .rd_sel   (tbl),
      .rd_base  (tbl_base),
      .rd_limit (tbl_limit)
   );

   dtf_entry_calc #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .VEC_W(VEC_W)) u_calc (
      .kind       (req_kind),
      .sel        (req_sel),
      .vec        (req_vec),
      .tbl        (tbl),
      .base       (tbl_base),
      .limit      (tbl_limit),
      .entry_addr (entry_addr),
      .flt        (flt)
   );

   dtf_fetch_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .start_addr (entry_addr),
      .start_flt  (flt),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .done       (done),
      .fault      (fault),
      .fault_code (fault_code),
      .desc       (desc)
   );

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && !fault) |=> busy);

   // R9
   done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fault));

   // R8
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy && !done && !fault) |=> (busy && !$rose(mem_req)));
endmodule

// File: tb/dtab_fetch_tb_top.sv
`timescale 1ns/1ps
module dtab_fetch_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_base = '0;
   logic [15:0] cfg_limit = '0;
   logic        req_valid = 1'b0;
   logic        req_kind = 1'b0;
   logic [15:0] req_sel = '0;
   logic [7:0]  req_vec = '0;
   logic        busy, mem_req, done, fault;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [1:0]  fault_code;
   logic [63:0] desc;

   always #10 clk = ~clk;

   dtab_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_limit(cfg_limit), .req_valid(req_valid),
      .req_kind(req_kind), .req_sel(req_sel), .req_vec(req_vec), .busy(busy),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .done(done), .fault(fault),
      .fault_code(fault_code), .desc(desc)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   int waitn = 0;
   int wcnt = 0;
   int nreads = 0;
   logic [31:0] rd_log [4];
   logic [31:0] tb_base [3];
   logic [15:0] tb_lim [3];

   function automatic logic [31:0] memf(input logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
   endfunction

   // memory model: ack after waitn stall cycles, driven at negedge
   always @(negedge clk) begin
      if (mem_ack) begin
         mem_ack = 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt >= waitn) begin
            mem_ack = 1'b1;
            mem_rdata = memf(mem_addr);
            if (nreads < 4) rd_log[nreads] = mem_addr;
            nreads++;
         end else wcnt++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [31:0] b, input logic [15:0] l);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_base = b; cfg_limit = l;
      if (s != 2'd3) begin tb_base[s] = b; tb_lim[s] = l; end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // one fetch with expected values computed from the requirements
   task automatic fetch(input bit kind, input logic [15:0] sel, input logic [7:0] vec,
                        input int wt, input bit spam, input string req);
      int t;
      int idx;
      logic [1:0] ecode;
      logic [31:0] ea;
      int cyc;
      bit busy_ok;
      bit memq_ok;
      t = kind ? 2 : (sel[2] ? 1 : 0);
      idx = kind ? int'(vec) : int'(sel[15:3]);
      ea = tb_base[t] + 32'(idx * 8);
      if (!kind && !sel[2] && idx == 0) ecode = 2'd2;
      else if (idx * 8 + 7 > int'(tb_lim[t])) ecode = 2'd1;
      else ecode = 2'd0;
      waitn = wt; nreads = 0;
      @(negedge clk);
      req_kind = kind; req_sel = sel; req_vec = vec; req_valid = 1'b1;
      @(negedge clk);
      if (!spam) req_valid = 1'b0;
      else begin req_sel = sel ^ 16'h0F08; req_vec = vec ^ 8'h11; req_kind = ~kind; end
      cyc = 0; busy_ok = 1; memq_ok = 1;
      while (!(done || fault) && cyc < 100) begin
         if (!busy) busy_ok = 0;
         if (ecode != 0 && mem_req) memq_ok = 0;
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      check(busy_ok && busy, "R9", "busy held until pulse", 64'(busy), 64'd1);
      check(!(done && fault), "R9", "done/fault exclusive", {done, fault}, 64'd0);
      if (ecode != 0) begin
         check(fault && cyc == 0, req, "fault pulse one cycle after accept", 64'(cyc), 64'd0);
         check(fault_code == ecode, req, "fault code", 64'(fault_code), 64'(ecode));
         check(memq_ok && nreads == 0, "R4", "no memory read on fault", 64'(nreads), 64'd0);
      end else begin
         check(done, req, "done pulse", 64'(done), 64'd1);
         check(nreads == 2, "R6", "read count", 64'(nreads), 64'd2);
         check(rd_log[0] == ea, req, "first read address", 64'(rd_log[0]), 64'(ea));
         check(rd_log[1] == ea + 32'd4, "R6", "second read address", 64'(rd_log[1]), 64'(ea + 32'd4));
         check(desc == {memf(ea + 32'd4), memf(ea)}, "R7", "descriptor", desc,
               {memf(ea + 32'd4), memf(ea)});
      end
      @(negedge clk);
      check(!busy && !done && !fault, "R9", "idle after pulse", {busy, done, fault}, 64'd0);
      if (spam) begin
         @(negedge clk);
         @(negedge clk);
         check(!busy && !mem_req && nreads == (ecode != 0 ? 0 : 2), "R8",
               "request during busy ignored", 64'(nreads), 64'(ecode != 0 ? 0 : 2));
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) begin tb_base[i] = '0; tb_lim[i] = '0; end
      repeat (3) @(negedge clk);
      // R1
      check(!busy && !mem_req && !done && !fault, "R1", "reset outputs",
            {mem_req, busy, done, fault}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !mem_req && !done && !fault, "R1", "idle after reset",
            {mem_req, busy, done, fault}, 64'd0);

      // R10: load tables, including a wrapping base
      cfg_write(2'd0, 32'h0001_0000, 16'h003F);
      cfg_write(2'd1, 32'hFFFF_FFE8, 16'h002B);
      cfg_write(2'd2, 32'h0000_8000, 16'h007F);
      cfg_write(2'd3, 32'hDEAD_0000, 16'hFFFF);

      // R2/R5/R4: global sweep with varying low bits
      for (int i = 0; i < 10; i++)
         fetch(1'b0, {13'(i), 1'b0, 2'(i)}, 8'd0, i % 4, 1'b0, i == 0 ? "R5" : (i >= 8 ? "R4" : "R2"));
      // R10: sel 3 write left global alone (index 1 address checked above and here)
      fetch(1'b0, 16'h0008, 8'd0, 0, 1'b0, "R10");
      // R2/R5/R4: local table, limit not 8-aligned, wrapping base
      for (int i = 0; i < 7; i++)
         fetch(1'b0, {13'(i), 1'b1, 2'(3 - (i % 4))}, 8'd0, (i + 1) % 4, 1'b0, i == 0 ? "R5" : (i >= 5 ? "R4" : "R2"));
      // R3/R4: vectors around the interrupt limit
      for (int v = 0; v < 20; v++)
         fetch(1'b1, 16'h0000, 8'(v), v % 3, 1'b0, v >= 16 ? "R4" : "R3");
      fetch(1'b1, 16'h0000, 8'hFF, 1, 1'b0, "R4");
      // R3: full-size interrupt table, last vector
      cfg_write(2'd2, 32'h0020_0000, 16'h07FF);
      fetch(1'b1, 16'h0000, 8'hFF, 2, 1'b0, "R3");
      fetch(1'b1, 16'h0000, 8'h80, 0, 1'b0, "R3");
      // R4: maximum global table, last index
      cfg_write(2'd0, 32'h1000_0000, 16'hFFFF);
      fetch(1'b0, 16'hFFF8, 8'd0, 3, 1'b0, "R2");
      fetch(1'b0, 16'hFFFB, 8'd0, 0, 1'b0, "R2");
      // R8: requests held during busy, both success and fault
      fetch(1'b0, 16'h0123 & 16'hFFF8, 8'd0, 3, 1'b1, "R8");
      fetch(1'b0, 16'h0004 | 16'h0100, 8'd0, 0, 1'b1, "R8");
      fetch(1'b0, 16'h0000, 8'd0, 0, 1'b1, "R5");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule